// File: doc/BRIEF.md
# Dual-Reload Programmable Pulse Generator

This block generates a rectangular wave whose low time and high time are set independently. An 8-bit down counter is loaded with the reload value for the level the output currently holds. The counter decrements on each tick of a selectable count clock. When it passes zero, the output level flips and the counter is reloaded with the value for the new level. Changing the two reload values therefore sets both the period and the duty cycle.

The count clock comes from one of five prescaled clock-enable strobes, a slow timebase strobe, or, in cascade mode, the underflow strobe of a partner channel. Every underflow is exported as a one-cycle strobe, so a second channel can be chained behind this one. An underflow also sets a sticky flag. That flag, gated by an interrupt enable and ORed with the partner's request, drives the interrupt line.

The high reload byte is written through a staging buffer. It takes effect only when the low reload byte is written, so both halves change together.

Top module: `dual_reload_ppg`

## Requirements
- R1: After reset, every register reads 0 (control at address 0, clock select at address 1, low reload at address 2, high reload at address 3), and `pulse_out` and `irq_out` are low.
- R2: With reload values L (low) and H (high) and a count tick every P cycles, the output stays low for (L+1)·P cycles and high for (H+1)·P cycles, and it flips on every underflow.
- R3: Clock-select field [2:0] at address 1: the values 0 to 4 pick `div_tick[0..4]`, the value 5 picks `tb_tick`, and the values 6 and 7 give no count ticks, so the output never toggles.
- R4: Mode field bits [5:4] of the control register equal to 01 selects cascade mode. In this mode the counter decrements on `partner_uf` and ignores the clock-select field.
- R5: `uf_out` is high for exactly one cycle per underflow, and the number of `uf_out` pulses equals the number of output toggles.
- R6: Control bit 3 is the underflow flag. Hardware sets it one cycle after an underflow strobe. Writing 0 to it clears it, and writing 1 leaves it unchanged. A hardware set wins over a clear in the same cycle.
- R7: `irq_out` equals (flag AND control bit 2) OR `partner_irq`.
- R8: A write to address 3 only stages the byte, and address 3 keeps reading the previous high reload. The staged byte becomes the active high reload when address 2 is written.
- R9: While control bit 0 (run) is clear, the output latch is low. After run is set, the low reload is loaded on the next edge, and counting begins on the edge after that.
- R10: While control bit 1 (pin enable) is clear, `pulse_out` is low, but counting and `uf_out` strobes continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| div_tick | input | 5 | Prescaled clock-enable strobes, divide by 1, 2, 4, 8 and 16 |
| tb_tick | input | 1 | Timebase clock-enable strobe |
| partner_uf | input | 1 | Underflow strobe from the partner channel |
| partner_irq | input | 1 | Interrupt request from the partner channel |
| pulse_out | output | 1 | Pulse pin |
| uf_out | output | 1 | Underflow strobe to the partner channel |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest condition to reach from the ports is cascade counting that provably ignores the prescaler. The bench drives `partner_uf` with a period of three cycles, which is no power of two. It also parks the clock-select field at a value with no ticks. A measured high or low time that is a multiple of three can then only come from the partner strobes. The staging behaviour of the high reload byte is reached by writing address 3 alone and reading back the active value before and after a later write to address 2.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int NUM_DIV = 5;
    localparam int SEL_W   = 3;
    localparam int SEL_TB  = NUM_DIV;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_CSEL = 2'd1,
        A_LOW  = 2'd2,
        A_HIGH = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_SOLO    = 2'b00,
        M_CASCADE = 2'b01,
        M_RSV2    = 2'b10,
        M_RSV3    = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  flag;
        logic  irq_en;
        logic  pin_en;
        logic  run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic pick_tick(input logic [SEL_W-1:0] sel,
                                       input logic [NUM_DIV-1:0] div,
                                       input logic tb);
        logic t;
        t = 1'b0;
        for (int k = 0; k < NUM_DIV; k++) begin
            if (int'(sel) == k) t = div[k];
        end
        if (int'(sel) == SEL_TB) t = tb;
        return t;
    endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [1:0]       rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic             uf_in,
    output ctrl_t            ctrl,
    output logic [SEL_W-1:0] csel,
    output logic [W-1:0]     low_rel,
    output logic [W-1:0]     high_rel
);
    reg_addr_e    waddr;
    reg_addr_e    raddr;
    logic [W-1:0] high_stage;
    logic         flag_clr;

    assign waddr    = reg_addr_e'(wr_addr);
    assign raddr    = reg_addr_e'(rd_addr);
    assign flag_clr = wr_en && (waddr == A_CTRL) && !wr_data[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            csel       <= '0;
            low_rel    <= '0;
            high_rel   <= '0;
            high_stage <= '0;
        end else begin
            if (wr_en) begin
                unique case (waddr)
                    A_CTRL: begin
                        ctrl.run    <= wr_data[0];
                        ctrl.pin_en <= wr_data[1];
                        ctrl.irq_en <= wr_data[2];
                        ctrl.mode   <= mode_e'(wr_data[5:4]);
                    end
                    A_CSEL: csel <= wr_data[SEL_W-1:0];
                    A_LOW: begin
                        low_rel  <= wr_data;
                        high_rel <= high_stage;
                    end
                    A_HIGH: high_stage <= wr_data;
                endcase
            end
            if (uf_in)         ctrl.flag <= 1'b1;
            else if (flag_clr) ctrl.flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (raddr)
            A_CTRL:  rd_data = W'(ctrl);
            A_CSEL:  rd_data = W'(csel);
            A_LOW:   rd_data = low_rel;
            A_HIGH:  rd_data = high_rel;
        endcase
    end

    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        uf_in |=> ctrl.flag);

    a_r8_stage_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == A_HIGH) |=> $stable(high_rel));

endmodule

// File: rtl/ppg_clksel.sv
module ppg_clksel
    import ppg_pkg::*;
(
    input  logic [SEL_W-1:0]   csel,
    input  mode_e              mode,
    input  logic [NUM_DIV-1:0] div_tick,
    input  logic               tb_tick,
    input  logic               partner_uf,
    output logic               tick
);
    always_comb begin
        if (mode == M_CASCADE) tick = partner_uf;
        else                   tick = pick_tick(csel, div_tick, tb_tick);
    end
endmodule

// File: rtl/ppg_core.sv
module ppg_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] low_rel,
    input  logic [W-1:0] high_rel,
    output logic         level,
    output logic         uf
);
    logic [W-1:0] cnt;
    logic         armed;
    logic         count_now;
    logic         wrap;

    assign count_now = run && !armed && tick;
    assign wrap      = count_now && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
            armed <= 1'b1;
            uf    <= 1'b0;
        end else begin
            uf <= wrap;
            if (!run) begin
                armed <= 1'b1;
                level <= 1'b0;
            end else if (armed) begin
                cnt   <= low_rel;
                armed <= 1'b0;
            end else if (count_now) begin
                if (cnt == '0) begin
                    level <= ~level;
                    cnt   <= level ? low_rel : high_rel;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    a_r2_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        uf |-> (level != $past(level)));

    a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !level);

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (run && !armed && !tick) |=> $stable(cnt));

endmodule

// File: rtl/dual_reload_ppg.sv
module dual_reload_ppg
    import ppg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [W-1:0]       wr_data,
    input  logic [1:0]         rd_addr,
    output logic [W-1:0]       rd_data,
    input  logic [NUM_DIV-1:0] div_tick,
    input  logic               tb_tick,
    input  logic               partner_uf,
    input  logic               partner_irq,
    output logic               pulse_out,
    output logic               uf_out,
    output logic               irq_out
);
    ctrl_t            ctrl;
    logic [SEL_W-1:0] csel;
    logic [W-1:0]     low_rel;
    logic [W-1:0]     high_rel;
    logic             tick;
    logic             level;

    ppg_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .uf_in    (uf_out),
        .ctrl     (ctrl),
        .csel     (csel),
        .low_rel  (low_rel),
        .high_rel (high_rel)
    );

    ppg_clksel u_clksel (
        .csel       (csel),
        .mode       (ctrl.mode),
        .div_tick   (div_tick),
        .tb_tick    (tb_tick),
        .partner_uf (partner_uf),
        .tick       (tick)
    );

    ppg_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .tick     (tick),
        .low_rel  (low_rel),
        .high_rel (high_rel),
        .level    (level),
        .uf       (uf_out)
    );

    assign pulse_out = level && ctrl.pin_en;
    assign irq_out   = (ctrl.flag && ctrl.irq_en) || partner_irq;

endmodule

// File: tb/dual_reload_ppg_bench.sv
module dual_reload_ppg_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] div_tick;
    logic       tb_tick;
    logic       partner_uf = 1'b0;
    logic       partner_irq = 1'b0;
    logic       pulse_out;
    logic       uf_out;
    logic       irq_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  tcnt     = 0;
    int  pcnt     = 0;
    bit  cas_on   = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    dual_reload_ppg u_dual_reload_ppg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .div_tick(div_tick), .tb_tick(tb_tick), .partner_uf(partner_uf),
        .partner_irq(partner_irq), .pulse_out(pulse_out),
        .uf_out(uf_out), .irq_out(irq_out)
    );

    always @(negedge clk) begin
        tcnt <= tcnt + 1;
        pcnt <= (pcnt == 2) ? 0 : pcnt + 1;
        partner_uf <= cas_on && (pcnt == 0);
    end

    always_comb begin
        for (int k = 0; k < 5; k++) div_tick[k] = (tcnt % (1 << k)) == 0;
        tb_tick = (tcnt % 512) == 0;
    end

    // {sel, mode, low, high}
    localparam logic [7:0] VEC [6][4] = '{
        '{8'd0, 8'd0, 8'd3, 8'd1},
        '{8'd1, 8'd0, 8'd2, 8'd4},
        '{8'd0, 8'd0, 8'd0, 8'd0},
        '{8'd4, 8'd0, 8'd1, 8'd2},
        '{8'd5, 8'd0, 8'd1, 8'd0},
        '{8'd7, 8'd1, 8'd2, 8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        while (pulse_out == 1'b1 && guard < 5000) begin guard++; @(negedge clk); end
        guard = 0;
        while (pulse_out == 1'b0 && guard < 5000) begin guard++; @(negedge clk); end
        while (pulse_out == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
        while (pulse_out == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int v, hi, lo, per, ufs, tog, prev, k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 register reset", v, 0);
        end
        check("R1 pulse reset", int'(pulse_out), 0);
        check("R1 irq reset", int'(irq_out), 0);

        // R2/R3/R4 vector table
        for (int i = 0; i < 6; i++) begin
            cas_on = (VEC[i][1] == 8'd1);
            wr(2'd0, 8'h00);
            wr(2'd1, VEC[i][0]);
            wr(2'd3, VEC[i][3]);
            wr(2'd2, VEC[i][2]);
            wr(2'd0, {2'b00, VEC[i][1][1:0], 4'b0011});
            if (cas_on) per = 3;
            else if (VEC[i][0] == 8'd5) per = 512;
            else per = 1 << VEC[i][0];
            measure(hi, lo);
            check(cas_on ? "R4 cascade high time" : "R2 R3 high time",
                  hi, (int'(VEC[i][3]) + 1) * per);
            check(cas_on ? "R4 cascade low time" : "R2 R3 low time",
                  lo, (int'(VEC[i][2]) + 1) * per);
        end
        cas_on = 1'b0;

        // R3 select 6 gives no ticks
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd6);
        wr(2'd0, 8'h03);
        ufs = 0; tog = 0;
        repeat (100) begin
            @(negedge clk);
            ufs += int'(uf_out);
            tog += int'(pulse_out);
        end
        check("R3 select 6 no underflow", ufs, 0);
        check("R3 select 6 output low", tog, 0);

        // R9 first low interval after enable, divide by 1, L=5
        wr(2'd0, 8'h00);
        wr(2'd1, 8'd0);
        wr(2'd3, 8'd5);
        wr(2'd2, 8'd5);
        wr(2'd0, 8'h03);
        k = 0;
        while (pulse_out == 1'b0 && k < 100) begin k++; @(negedge clk); end
        check("R9 load then count from low", k, 7);
        wr(2'd0, 8'h02);
        repeat (3) @(negedge clk);
        check("R9 stopped output low", int'(pulse_out), 0);

        // R5 one strobe per toggle, L=H=3
        wr(2'd3, 8'd3);
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h03);
        ufs = 0; tog = 0; prev = int'(pulse_out); v = 0;
        repeat (60) begin
            @(negedge clk);
            if (uf_out && v == 1) ufs += 1000;
            v = int'(uf_out);
            ufs += int'(uf_out);
            if (int'(pulse_out) != prev) tog++;
            prev = int'(pulse_out);
        end
        check("R5 strobes equal toggles", ufs, tog);
        check("R5 toggles seen", int'(tog > 10), 1);

        // R10 pin disabled
        wr(2'd0, 8'h01);
        ufs = 0; tog = 0;
        repeat (40) begin
            @(negedge clk);
            ufs += int'(uf_out);
            tog += int'(pulse_out);
        end
        check("R10 pin held low", tog, 0);
        check("R10 strobes continue", int'(ufs > 0), 1);

        // R6/R7 flag and interrupt
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h00);
        rd(2'd0, v);
        check("R6 flag cleared by zero write", (v >> 3) & 1, 0);
        wr(2'd0, 8'h07);
        k = 0;
        while (uf_out == 1'b0 && k < 100) begin k++; @(negedge clk); end
        @(negedge clk);
        rd(2'd0, v);
        check("R6 flag set by underflow", (v >> 3) & 1, 1);
        check("R7 irq from flag", int'(irq_out), 1);
        wr(2'd0, 8'h08);
        rd(2'd0, v);
        check("R6 write one keeps flag", (v >> 3) & 1, 1);
        check("R7 irq masked", int'(irq_out), 0);
        wr(2'd0, 8'h04);
        rd(2'd0, v);
        check("R6 write zero clears flag", (v >> 3) & 1, 0);
        check("R7 irq low after clear", int'(irq_out), 0);
        partner_irq = 1'b1;
        #1;
        check("R7 partner irq passes", int'(irq_out), 1);
        partner_irq = 1'b0;

        // R8 staged high byte
        wr(2'd3, 8'd9);
        wr(2'd2, 8'd2);
        rd(2'd3, v);
        check("R8 high after low write", v, 9);
        wr(2'd3, 8'd20);
        rd(2'd3, v);
        check("R8 high staged only", v, 9);
        wr(2'd2, 8'd2);
        rd(2'd3, v);
        check("R8 high transferred", v, 20);

        finish_run();
    end

endmodule